// File: doc/BRIEF.md
# Multi-Channel Output Compare Timer

This block keeps a 16-bit up-counter that advances on ticks of a selectable clock divider. Five compare channels each hold a 16-bit value. When the counter steps onto a channel's value, that channel raises a sticky status flag, and it can also change one or more output pins. Software sets up the block and services it through a small register port with single-cycle writes and a combinational read. The block reports through its flag outputs, one interrupt line and five pin outputs.

Channels 2 to 5 each own one pin, and each applies a two-bit action code when it fires. Channel 1 acts on a group of pins: a mask register picks which of the five pins it drives, and a data register supplies the level for each of them. A force register fires any set of channels at once. A forced channel performs its pin action but does not raise its flag, so software can preset pin levels before a compare run. The register port is plain control access with no back-pressure: every write takes effect at the next clock edge, and a read returns data in the same cycle.

Register map (4-bit address): 0 counter (read only), 1 to 5 compare values of channels 1 to 5, 8 action codes, 9 group mask, 10 group data, 11 divider select, 12 flags, 13 interrupt enables, 14 force (reads as zero).

Top module: `oct_top`

## Requirements
- R1: Reset clears the counter to 0x0000. After that the counter rises by exactly one on every divider tick, wraps from 0xFFFF to 0x0000, and never changes between ticks. It reads back at address 0.
- R2: The divider select at address 11, bits [1:0], gives a tick once every 1, 4, 8 or 16 clocks for the values 0, 1, 2 or 3. Its phase comes from a free-running 4-bit prescale count that reset clears to zero.
- R3: Reset loads every compare value with 0xFFFF. Each compare value can be written and read back at its address, 1 to 5.
- R4: On a tick where the counter's new value equals a channel's compare value (the value held before that edge), flag bit i-1 of channel i is set at that same edge. The flags appear at address 12, bits [4:0], and on `cmp_flag`.
- R5: The overflow flag (address 12 bit 5, `ovf_flag`) is set at the edge where the counter wraps from 0xFFFF to 0x0000.
- R6: Writing 1 to a flag bit at address 12 clears that flag, and writing 0 leaves it unchanged. A set and a clear at the same edge leave the flag set.
- R7: `irq` is high exactly when some flag is set whose enable bit at address 13 is set. Bits [4:0] enable the channel flags and bit 5 enables the overflow flag.
- R8: Channel k (k = 2 to 5) drives pin k-1 with its code at address 8, bits [2k-3:2k-4]: 00 leaves the pin alone, 01 inverts it, 10 drives 0 and 11 drives 1. Pin 0 is driven by channel 1 only. Reset makes all pins 0.
- R9: When channel 1 fires, every pin whose bit is set in the group mask (address 9) takes the matching bit of the group data (address 10), and pins outside the mask are left alone.
- R10: Writing 1 to bit i-1 of the force register (address 14) performs channel i's pin action at that edge without setting its flag. The register reads as 0.
- R11: When channel 1 and a per-pin channel act on the same pin at the same edge, the pin takes channel 1's data.
- R12: A match acts only once per counter value. While the counter holds a value between ticks, a flag that is cleared stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Register address for reads and writes |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, same cycle |
| cmp_flag | output | 5 | Sticky compare flags, bit i-1 for channel i |
| ovf_flag | output | 1 | Sticky counter wrap flag |
| irq | output | 1 | Interrupt request from enabled flags |
| pin_out | output | 5 | Compare pin outputs |

## Verification
The assertions assume that reset is held for at least one clock edge. They also assume that the port inputs change only between edges, so that a flag falls only in the cycle after a clearing write and a pin moves only after a tick or a force write. The stimulus drives every input one nanosecond after a rising edge and samples outputs on the falling edge. It writes at most one register per cycle and uses only mapped addresses. Deliberate races, such as a clear that lands on a match edge and a simultaneous force of both channel kinds, are timed from counter values read back through the port.

// File: rtl/oct_pkg.sv
package oct_pkg;

  // register addresses
  localparam logic [3:0] ADR_COUNT  = 4'd0;
  localparam logic [3:0] ADR_ACTION = 4'd8;
  localparam logic [3:0] ADR_MASK   = 4'd9;
  localparam logic [3:0] ADR_DATA   = 4'd10;
  localparam logic [3:0] ADR_PRESC  = 4'd11;
  localparam logic [3:0] ADR_FLAGS  = 4'd12;
  localparam logic [3:0] ADR_IEN    = 4'd13;
  localparam logic [3:0] ADR_FORCE  = 4'd14;

  localparam int PRE_W = 4;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_HIGH   = 2'b11
  } pin_act_e;

  // low bits of the prescale count that must all be one for a tick
  function automatic logic [PRE_W-1:0] div_mask(input logic [1:0] sel);
    case (sel)
      2'd0:    div_mask = 4'h0;
      2'd1:    div_mask = 4'h3;
      2'd2:    div_mask = 4'h7;
      default: div_mask = 4'hF;
    endcase
  endfunction

endpackage

// File: rtl/oct_timebase.sv
module oct_timebase
  import oct_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       div_sel,
  output logic             tick,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] count_next,
  output logic             wrap
);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_sel;

  assign pre_sel    = div_mask(div_sel);
  assign tick       = (pre_q & pre_sel) == pre_sel;
  assign count_next = count + CNT_W'(1);
  assign wrap       = tick && (&count);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
      count <= '0;
    end else begin
      pre_q <= pre_q + PRE_W'(1);
      if (tick) count <= count_next;
    end
  end

endmodule

// File: rtl/oct_compare.sv
module oct_compare #(
  parameter int CNT_W = 16
) (
  input  logic             tick,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic [CNT_W-1:0] count_next,
  output logic             hit
);

  // only the value the counter is about to take can match
  assign hit = tick && (cmp_val == count_next);

endmodule

// File: rtl/oct_pin_drive.sv
module oct_pin_drive
  import oct_pkg::*;
#(
  parameter int NUM_CH = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH-1:0]       fire,
  input  logic [2*(NUM_CH-1)-1:0] codes,
  input  logic [NUM_CH-1:0]       grp_mask,
  input  logic [NUM_CH-1:0]       grp_data,
  output logic [NUM_CH-1:0]       pins
);

  logic [NUM_CH-1:0] pins_d;

  always_comb begin
    pins_d = pins;
    for (int k = 1; k < NUM_CH; k++) begin
      if (fire[k]) begin
        case (pin_act_e'(codes[2*k-2 +: 2]))
          ACT_TOGGLE: pins_d[k] = ~pins[k];
          ACT_LOW:    pins_d[k] = 1'b0;
          ACT_HIGH:   pins_d[k] = 1'b1;
          default:    pins_d[k] = pins[k];
        endcase
      end
    end
    // group channel applied last so it takes precedence
    if (fire[0]) pins_d = (pins_d & ~grp_mask) | (grp_data & grp_mask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pins <= '0;
    else        pins <= pins_d;
  end

endmodule

// File: rtl/oct_top.sv
module oct_top
  import oct_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic [NUM_CH-1:0] cmp_flag,
  output logic              ovf_flag,
  output logic              irq,
  output logic [NUM_CH-1:0] pin_out
);

  localparam int ACT_W = 2 * (NUM_CH - 1);
  localparam int FLG_W = NUM_CH + 1;

  logic             tick;
  logic             wrap;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] count_next;

  logic [CNT_W-1:0]  cmp_q [NUM_CH];
  logic [ACT_W-1:0]  act_q;
  logic [NUM_CH-1:0] mask_q;
  logic [NUM_CH-1:0] data_q;
  logic [1:0]        presc_q;
  logic [FLG_W-1:0]  ien_q;

  logic [NUM_CH-1:0] match_vec;
  logic [NUM_CH-1:0] force_vec;
  logic [NUM_CH-1:0] fire_vec;
  logic [NUM_CH-1:0] clr_vec;
  logic              clr_ovf;
  logic              wr_flags;

  oct_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk        (clk),
    .rst_n      (rst_n),
    .div_sel    (presc_q),
    .tick       (tick),
    .count      (count),
    .count_next (count_next),
    .wrap       (wrap)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n)                                   cmp_q[g] <= '1;
      else if (reg_we && reg_addr == 4'(g + 1))     cmp_q[g] <= reg_wdata;
    end

    oct_compare #(.CNT_W(CNT_W)) u_cmp (
      .tick       (tick),
      .cmp_val    (cmp_q[g]),
      .count_next (count_next),
      .hit        (match_vec[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q   <= '0;
      mask_q  <= '0;
      data_q  <= '0;
      presc_q <= '0;
      ien_q   <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        ADR_ACTION: act_q   <= reg_wdata[ACT_W-1:0];
        ADR_MASK:   mask_q  <= reg_wdata[NUM_CH-1:0];
        ADR_DATA:   data_q  <= reg_wdata[NUM_CH-1:0];
        ADR_PRESC:  presc_q <= reg_wdata[1:0];
        ADR_IEN:    ien_q   <= reg_wdata[FLG_W-1:0];
        default:    ;
      endcase
    end
  end

  // write-one-to-clear flags; a set at the same edge wins
  assign wr_flags = reg_we && (reg_addr == ADR_FLAGS);
  assign clr_vec  = wr_flags ? reg_wdata[NUM_CH-1:0] : '0;
  assign clr_ovf  = wr_flags && reg_wdata[NUM_CH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_flag <= '0;
      ovf_flag <= 1'b0;
    end else begin
      cmp_flag <= (cmp_flag & ~clr_vec) | match_vec;
      ovf_flag <= (ovf_flag & ~clr_ovf) | wrap;
    end
  end

  assign irq = |({ovf_flag, cmp_flag} & ien_q);

  assign force_vec = (reg_we && reg_addr == ADR_FORCE) ? reg_wdata[NUM_CH-1:0] : '0;
  assign fire_vec  = match_vec | force_vec;

  oct_pin_drive #(.NUM_CH(NUM_CH)) u_pins (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire_vec),
    .codes    (act_q),
    .grp_mask (mask_q),
    .grp_data (data_q),
    .pins     (pin_out)
  );

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (reg_addr == 4'(i + 1)) reg_rdata = cmp_q[i];
    end
    case (reg_addr)
      ADR_COUNT:  reg_rdata = count;
      ADR_ACTION: reg_rdata = CNT_W'(act_q);
      ADR_MASK:   reg_rdata = CNT_W'(mask_q);
      ADR_DATA:   reg_rdata = CNT_W'(data_q);
      ADR_PRESC:  reg_rdata = CNT_W'(presc_q);
      ADR_FLAGS:  reg_rdata = CNT_W'({ovf_flag, cmp_flag});
      ADR_IEN:    reg_rdata = CNT_W'(ien_q);
      default:    ;
    endcase
  end

endmodule

// File: rtl/oct_checker.sv
module oct_checker
  import oct_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  cmp_q [NUM_CH],
  input logic [NUM_CH-1:0] cmp_flag,
  input logic              ovf_flag,
  input logic              irq,
  input logic [NUM_CH-1:0] pin_out,
  input logic              reg_we,
  input logic [3:0]        reg_addr,
  input logic [CNT_W-1:0]  reg_wdata
);

  // one clean cycle after reset before any history is trusted
  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (count != $past(count)) |-> (count == $past(count) + 1'b1));

  assert_count_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(tick) |-> (count != $past(count)));

  assert_wrap_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $rose(ovf_flag) |-> (count == '0));

  assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|{ovf_flag, cmp_flag}));

  assert_pins_hold_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (!$past(tick) && !$past(reg_we && reg_addr == ADR_FORCE)) |-> $stable(pin_out));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    assert_match_value_R4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      $rose(cmp_flag[g]) |-> (count == $past(cmp_q[g])));

    assert_clear_by_write_R6: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      $fell(cmp_flag[g]) |-> $past(reg_we && reg_addr == ADR_FLAGS && reg_wdata[g]));
  end

endmodule

bind oct_top oct_checker #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .count     (count),
  .cmp_q     (cmp_q),
  .cmp_flag  (cmp_flag),
  .ovf_flag  (ovf_flag),
  .irq       (irq),
  .pin_out   (pin_out),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata)
);

// File: tb/sim_oct_top.sv
`timescale 1ns/1ps
module sim_oct_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = 4'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic [4:0]  cmp_flag;
  logic        ovf_flag;
  logic        irq;
  logic [4:0]  pin_out;

  always #2 clk = ~clk;

  oct_top u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmp_flag(cmp_flag),
    .ovf_flag(ovf_flag), .irq(irq), .pin_out(pin_out)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  logic [15:0] m_cnt, m_cmp [5];
  logic [7:0]  m_act;
  logic [4:0]  m_mask, m_data, m_flag, m_pin;
  logic [1:0]  m_pre;
  logic [5:0]  m_ien;
  logic        m_ovf;
  int          m_pc;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_act = 0; m_mask = 0; m_data = 0; m_flag = 0; m_pin = 0;
      m_pre = 0; m_ien = 0; m_ovf = 0; m_pc = 0;
      foreach (m_cmp[i]) m_cmp[i] = 16'hFFFF;
    end else begin
      int div;
      bit tk;
      logic [15:0] nx;
      logic [4:0] hit, act;
      div = (m_pre == 0) ? 1 : (m_pre == 1) ? 4 : (m_pre == 2) ? 8 : 16;
      tk = (m_pc % div) == div - 1;
      nx = m_cnt + 16'd1;
      for (int i = 0; i < 5; i++) begin
        hit[i] = tk && (m_cmp[i] == nx);
        act[i] = hit[i] || (reg_we && reg_addr == 4'd14 && reg_wdata[i]);
      end
      if (reg_we && reg_addr == 4'd12) begin
        m_flag = m_flag & ~reg_wdata[4:0];
        if (reg_wdata[5]) m_ovf = 0;
      end
      m_flag = m_flag | hit;
      if (tk && m_cnt == 16'hFFFF) m_ovf = 1;
      for (int k = 1; k < 5; k++) begin
        if (act[k]) begin
          case (m_act[2*k-2 +: 2])
            2'b01: m_pin[k] = ~m_pin[k];
            2'b10: m_pin[k] = 1'b0;
            2'b11: m_pin[k] = 1'b1;
            default: ;
          endcase
        end
      end
      if (act[0])
        for (int p = 0; p < 5; p++) if (m_mask[p]) m_pin[p] = m_data[p];
      if (reg_we) begin
        if (reg_addr >= 1 && reg_addr <= 5) m_cmp[reg_addr - 1] = reg_wdata;
        if (reg_addr == 4'd8)  m_act  = reg_wdata[7:0];
        if (reg_addr == 4'd9)  m_mask = reg_wdata[4:0];
        if (reg_addr == 4'd10) m_data = reg_wdata[4:0];
        if (reg_addr == 4'd11) m_pre  = reg_wdata[1:0];
        if (reg_addr == 4'd13) m_ien  = reg_wdata[5:0];
      end
      m_pc = (m_pc + 1) % 16;
      if (tk) m_cnt = nx;
    end
  end

  function automatic logic [15:0] m_read(input logic [3:0] a);
    case (a)
      4'd0: return m_cnt;
      4'd1, 4'd2, 4'd3, 4'd4, 4'd5: return m_cmp[a - 1];
      4'd8: return {8'd0, m_act};
      4'd9: return {11'd0, m_mask};
      4'd10: return {11'd0, m_data};
      4'd11: return {14'd0, m_pre};
      4'd12: return {10'd0, m_ovf, m_flag};
      4'd13: return {10'd0, m_ien};
      default: return 16'd0;
    endcase
  endfunction

  // compare against the reference on every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R8/R9/R11 pins", {27'd0, pin_out}, {27'd0, m_pin});
      chk("R4/R6 flags", {27'd0, cmp_flag}, {27'd0, m_flag});
      chk("R5 overflow", {31'd0, ovf_flag}, {31'd0, m_ovf});
      chk("R7 irq", {31'd0, irq}, {31'd0, |({m_ovf, m_flag} & m_ien)});
      chk("R1/R3 readback", {16'd0, reg_rdata}, {16'd0, m_read(reg_addr)});
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 200000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    step();
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_we = 1'b0; reg_addr = 4'd0; reg_wdata = 16'd0;
  endtask

  task automatic rdchk(input string req, input logic [3:0] a, input logic [15:0] exp);
    step();
    reg_addr = a;
    @(negedge clk);
    chk(req, {16'd0, reg_rdata}, {16'd0, exp});
    reg_addr = 4'd0;
  endtask

  initial begin
    logic [15:0] c0, c1;
    // reset state
    repeat (3) step();
    @(negedge clk);
    chk("R1 count at reset", {16'd0, reg_rdata}, 32'd0);
    chk("R8 pins at reset", {27'd0, pin_out}, 32'd0);
    chk("R4 flags at reset", {26'd0, ovf_flag, cmp_flag}, 32'd0);
    step();
    rst_n = 1'b1;

    for (int i = 1; i <= 5; i++) rdchk("R3 compare reset value", 4'(i), 16'hFFFF);

    // ch2 toggle, ch3 drive 0, ch4 drive 1, ch5 none
    wr(4'd8, 16'b00_11_10_01);
    wr(4'd9, 16'b10011);
    wr(4'd10, 16'b10010);
    wr(4'd13, 16'h003F);
    wr(4'd2, 16'd100);
    wr(4'd3, 16'd120);
    wr(4'd4, 16'd110);
    wr(4'd5, 16'd105);
    wr(4'd1, 16'd130);
    rdchk("R3 compare readback", 4'd4, 16'd110);
    repeat (200) step();
    @(negedge clk);
    chk("R8/R9 pins after matches", {27'd0, pin_out}, 32'b11010);
    chk("R4 all channels matched", {27'd0, cmp_flag}, 32'h1F);
    chk("R7 irq raised", {31'd0, irq}, 32'd1);

    // write-one-to-clear
    wr(4'd12, 16'h0000);
    @(negedge clk);
    chk("R6 zero write keeps flags", {27'd0, cmp_flag}, 32'h1F);
    wr(4'd12, 16'h0005);
    @(negedge clk);
    chk("R6 partial clear", {27'd0, cmp_flag}, 32'h1A);
    wr(4'd13, 16'h0000);
    @(negedge clk);
    chk("R7 irq masked", {31'd0, irq}, 32'd0);
    wr(4'd12, 16'h003F);

    // force: ch2 drive 0, ch3 drive 1
    wr(4'd8, 16'b00_11_11_10);
    wr(4'd14, 16'b00110);
    @(negedge clk);
    chk("R10 forced pin actions", {27'd0, pin_out}, 32'b11100);
    chk("R10 force leaves flags", {27'd0, cmp_flag}, 32'd0);
    rdchk("R10 force reads zero", 4'd14, 16'd0);

    // ch1 and ch2 forced together on pin 1
    wr(4'd8, 16'b00_11_11_11);
    wr(4'd10, 16'b10000);
    wr(4'd14, 16'b00011);
    @(negedge clk);
    chk("R11 group channel wins", {27'd0, pin_out}, 32'b11100);

    // clear and match at the same edge
    wr(4'd13, 16'h003F);
    step();
    @(negedge clk);
    c0 = reg_rdata;
    wr(4'd1, c0 + 16'd4);
    wr(4'd12, 16'h0001);
    @(negedge clk);
    chk("R6 set wins over clear", {31'd0, cmp_flag[0]}, 32'd1);

    // divider rates
    for (int s = 1; s <= 3; s++) begin
      wr(4'd11, 16'(s));
      step();
      @(negedge clk);
      c0 = reg_rdata;
      repeat (64) step();
      @(negedge clk);
      c1 = reg_rdata;
      chk("R2 ticks per 64 clocks", {16'd0, c1 - c0}, 32'(64 >> (s + 1)));
    end

    // one action per counter value (divide by 16 active)
    step();
    @(negedge clk);
    c0 = reg_rdata;
    wr(4'd12, 16'h003F);
    wr(4'd2, c0 + 16'd2);
    for (int w = 0; w < 80 && !cmp_flag[1]; w++) step();
    wr(4'd12, 16'h0002);
    repeat (4) step();
    @(negedge clk);
    chk("R12 no second match while held", {31'd0, cmp_flag[1]}, 32'd0);

    // counter wrap
    wr(4'd11, 16'd0);
    wr(4'd12, 16'h003F);
    wr(4'd5, 16'h0000);
    wr(4'd13, 16'h0020);
    for (int w = 0; w < 70000 && !ovf_flag; w++) step();
    @(negedge clk);
    chk("R5 wrap sets overflow", {31'd0, ovf_flag}, 32'd1);
    chk("R4 match at zero", {31'd0, cmp_flag[4]}, 32'd1);
    chk("R7 overflow interrupt", {31'd0, irq}, 32'd1);
    chk("R1 count just wrapped", {31'd0, reg_rdata < 16'd8}, 32'd1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule